// File: doc/BRIEF.md
# SPI Master Register Front-End

This block sits between a 32-bit word-addressed CPU bus and a byte-wide serial exchange engine. Software queues outgoing bytes in a transmit FIFO and collects returned bytes from a receive FIFO. A small drain controller moves bytes from the transmit FIFO to the engine, one exchange at a time, over a request/acknowledge handshake. Each byte the engine returns is pushed into the receive FIFO.

Software controls the block through registers for control, status, chip select, FIFO occupancy, a keyed soft reset and three interrupt words. The interrupt words are global enable, enable mask and sticky event status. Receive-side events also leave the block as one-cycle pulses, so that outside interrupt logic can combine them. A control bit can hold back new exchanges, which lets software fill the transmit queue before anything goes out.

Reads return data one cycle after the request, with `bus_rvalid` high in that cycle. Reading the receive-data word pops the receive FIFO. When the receive FIFO is empty, that read returns a fixed poison word instead.

Top module: `spi_regfront`

## Requirements
- R1: After reset, the registers read as follows: status = 0x5, both occupancy words = 0, control = 0, and the select word has all NUM_SS bits set. `ss_n` is all ones and `xfer_req` is low.
- R2: A write to transmit data (word 0x1A) queues bits [7:0] of the written value. While exchanges are not held back, queued bytes go to the engine in write order. `xfer_req` and `xfer_tx` stay unchanged until `xfer_ack`, and `xfer_req` drops in the cycle after the acknowledge. Only one exchange is outstanding at a time.
- R3: Each byte returned on `xfer_rx` with `xfer_ack` is stored in the receive FIFO in arrival order. A read of receive data (word 0x1B) returns the oldest stored byte in bits [7:0] with zeros above it, and removes that byte.
- R4: A read of receive data while the receive FIFO is empty returns 0xDEADBEEF and changes no state.
- R5: A byte that returns while the receive FIFO holds FIFO_DEPTH bytes is discarded. The block then pulses `evt_rx_overrun` and sets status event bit 0 in word 0x08. The stored bytes are left intact.
- R6: A store that brings the receive FIFO to FIFO_DEPTH bytes pulses `evt_rx_filled` and sets event bit 1. Every store pulses `evt_rx_stored` and sets event bit 2.
- R7: While control bit 8 (word 0x18) is set, no new exchange starts. Clearing the bit resumes draining.
- R8: Writing control bit 5 empties the transmit FIFO, and writing control bit 6 empties the receive FIFO. Both bits read back as 0. The other written control bits are kept.
- R9: Writing exactly 0xA to word 0x10 returns every register and both FIFOs to their reset state. Writing any other value there changes nothing.
- R10: The status word (0x19) reads {tx_full, tx_empty, rx_full, rx_empty} in bits [3:0], with zeros above. Writes to it are ignored.
- R11: Words 0x1D and 0x1E read the transmit and receive FIFO byte counts. Writes to them are ignored.
- R12: A transmit-data write while the transmit FIFO is full is dropped and leaves the count at FIFO_DEPTH.
- R13: `ss_n[i]` equals bit i of the select word (0x1C) written last.
- R14: Event bits in word 0x08 stay set until cleared. A write to word 0x08 inverts each bit written as 1. Words 0x07 and 0x0A read back the value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| xfer_req | output | 1 | Exchange request to the engine |
| xfer_tx | output | DW | Byte to send, stable while xfer_req |
| xfer_ack | input | 1 | Engine finished the exchange |
| xfer_rx | input | DW | Returned byte, valid with xfer_ack |
| ss_n | output | NUM_SS | Active-low chip selects |
| evt_rx_overrun | output | 1 | Pulse: returned byte dropped |
| evt_rx_filled | output | 1 | Pulse: receive FIFO became full |
| evt_rx_stored | output | 1 | Pulse: returned byte stored |

## Verification
Any error in a FIFO pointer or count shows up within one exchange as a wrong byte value or order at the receive-data port. It also shows as an occupancy word that disagrees with the number of writes and exchanges counted at the pins. All 256 byte values are sent through a bit-inverting engine model with ack delays of one to four cycles, and each returned byte is compared with its arithmetic expectation. The FIFO boundaries are driven exactly to full: the fill pulse, the overrun drop and the dropped transmit write are each visible at the ports in the cycle they occur. The handshake rules on `xfer_req` are checked on every clock.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
  localparam int REG_AW = 5;

  // register word indices
  localparam logic [REG_AW-1:0] A_GIE   = 5'h07;
  localparam logic [REG_AW-1:0] A_ISR   = 5'h08;
  localparam logic [REG_AW-1:0] A_IER   = 5'h0A;
  localparam logic [REG_AW-1:0] A_SRST  = 5'h10;
  localparam logic [REG_AW-1:0] A_CTRL  = 5'h18;
  localparam logic [REG_AW-1:0] A_STAT  = 5'h19;
  localparam logic [REG_AW-1:0] A_TXD   = 5'h1A;
  localparam logic [REG_AW-1:0] A_RXD   = 5'h1B;
  localparam logic [REG_AW-1:0] A_SS    = 5'h1C;
  localparam logic [REG_AW-1:0] A_TXOCC = 5'h1D;
  localparam logic [REG_AW-1:0] A_RXOCC = 5'h1E;

  localparam logic [31:0] SRST_KEY     = 32'h0000_000A;
  localparam logic [31:0] EMPTY_POISON = 32'hDEAD_BEEF;

  // control bit positions
  localparam int CTL_TXRST   = 5;
  localparam int CTL_RXRST   = 6;
  localparam int CTL_INHIBIT = 8;

  // event bit positions in the sticky status word
  localparam int EV_OVR   = 0;
  localparam int EV_FILL  = 1;
  localparam int EV_STORE = 2;

  typedef enum logic [1:0] {DR_IDLE, DR_FETCH, DR_XFER} drain_st_e;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   push,
  input  logic [W-1:0]           din,
  input  logic                   pop,
  output logic [W-1:0]           dout,
  output logic [$clog2(DEPTH):0] count,
  output logic                   full,
  output logic                   empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage and registered read port, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spi_drain_ctrl.sv
module spi_drain_ctrl
  import spi_regfront_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tx_empty,
  input  logic xfer_ack,
  output logic tx_pop,
  output logic xfer_req,
  output logic rx_push
);
  drain_st_e st;

  assign tx_pop   = (st == DR_IDLE) && !hold && !tx_empty;
  assign xfer_req = (st == DR_XFER);
  assign rx_push  = (st == DR_XFER) && xfer_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= DR_IDLE;
    end else begin
      case (st)
        DR_IDLE:  if (tx_pop) st <= DR_FETCH;
        DR_FETCH: st <= DR_XFER;
        DR_XFER:  if (xfer_ack) st <= DR_IDLE;
        default:  st <= DR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int NUM_SS     = 1,
  parameter int FIFO_DEPTH = 256,
  parameter int DW         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              xfer_req,
  output logic [DW-1:0]     xfer_tx,
  input  logic              xfer_ack,
  input  logic [DW-1:0]     xfer_rx,
  output logic [NUM_SS-1:0] ss_n,
  output logic              evt_rx_overrun,
  output logic              evt_rx_filled,
  output logic              evt_rx_stored
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic          wr, rd, soft_hit, srst, ctrl_wr;
  logic          tx_flush, rx_flush, tx_push, rx_pop, tx_pop, rx_push;
  logic          inhibit, drain_hold;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_dout;
  logic          ev_ovr, ev_store, ev_fill;
  logic [31:0]   ev_vec, rd_mux, rdata_q;
  logic [31:0]   gie_q, ier_q, isr_q, ctrl_q;
  logic [NUM_SS-1:0] ss_q;
  logic          rx_sel;

  assign wr       = bus_en && bus_we;
  assign rd       = bus_en && !bus_we;
  assign soft_hit = wr && (bus_addr == A_SRST) && (bus_wdata == SRST_KEY);
  assign srst     = rst || soft_hit;
  assign ctrl_wr  = wr && (bus_addr == A_CTRL);
  assign tx_flush = ctrl_wr && bus_wdata[CTL_TXRST];
  assign rx_flush = ctrl_wr && bus_wdata[CTL_RXRST];
  assign tx_push  = wr && (bus_addr == A_TXD);
  assign rx_pop   = rd && (bus_addr == A_RXD);
  assign inhibit  = ctrl_q[CTL_INHIBIT];
  // a flush in the same cycle must not let a stale byte go out
  assign drain_hold = inhibit || tx_flush;

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_txq (
    .clk(clk), .rst(srst), .flush(tx_flush),
    .push(tx_push), .din(bus_wdata[DW-1:0]),
    .pop(tx_pop), .dout(xfer_tx),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) u_rxq (
    .clk(clk), .rst(srst), .flush(rx_flush),
    .push(rx_push), .din(xfer_rx),
    .pop(rx_pop), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spi_drain_ctrl u_drain (
    .clk(clk), .rst(srst), .hold(drain_hold), .tx_empty(tx_empty),
    .xfer_ack(xfer_ack), .tx_pop(tx_pop), .xfer_req(xfer_req),
    .rx_push(rx_push)
  );

  // receive-side events
  assign ev_ovr   = rx_push && rx_full;
  assign ev_store = rx_push && !rx_full && !rx_flush;
  assign ev_fill  = ev_store && (rx_cnt == CW'(FIFO_DEPTH - 1)) &&
                    !(rx_pop && !rx_empty);

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_OVR]   = ev_ovr;
    ev_vec[EV_FILL]  = ev_fill;
    ev_vec[EV_STORE] = ev_store;
  end

  // register file
  always_ff @(posedge clk) begin
    if (srst) begin
      gie_q          <= '0;
      ier_q          <= '0;
      isr_q          <= '0;
      ctrl_q         <= '0;
      ss_q           <= '1;
      evt_rx_overrun <= 1'b0;
      evt_rx_filled  <= 1'b0;
      evt_rx_stored  <= 1'b0;
    end else begin
      evt_rx_overrun <= ev_ovr;
      evt_rx_filled  <= ev_fill;
      evt_rx_stored  <= ev_store;
      isr_q <= ((wr && bus_addr == A_ISR) ? (isr_q ^ bus_wdata) : isr_q) | ev_vec;
      if (wr) begin
        case (bus_addr)
          A_GIE:  gie_q  <= bus_wdata;
          A_IER:  ier_q  <= bus_wdata;
          A_CTRL: ctrl_q <= bus_wdata & ~((32'd1 << CTL_TXRST) | (32'd1 << CTL_RXRST));
          A_SS:   ss_q   <= bus_wdata[NUM_SS-1:0];
          default: ;
        endcase
      end
    end
  end

  assign ss_n = ss_q;

  // read path
  always_comb begin
    case (bus_addr)
      A_GIE:   rd_mux = gie_q;
      A_ISR:   rd_mux = isr_q;
      A_IER:   rd_mux = ier_q;
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  rd_mux = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:   rd_mux = rx_empty ? EMPTY_POISON : 32'd0;
      A_SS:    rd_mux = 32'(ss_q);
      A_TXOCC: rd_mux = 32'(tx_cnt);
      A_RXOCC: rd_mux = 32'(rx_cnt);
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      bus_rvalid <= 1'b0;
      rx_sel     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      bus_rvalid <= rd;
      rx_sel     <= rx_pop && !rx_empty;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rx_sel ? 32'(rx_dout) : rdata_q;
endmodule

// File: rtl/spi_regfront_checker.sv
module spi_regfront_checker #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   soft_hit,
  input logic                   xfer_req,
  input logic                   xfer_ack,
  input logic [DW-1:0]          xfer_tx,
  input logic                   inhibit,
  input logic                   evt_rx_overrun,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [$clog2(DEPTH):0] tx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  // R2: request and byte hold until the acknowledge
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack && !soft_hit) |=> (xfer_req && $stable(xfer_tx)));

  // R2: one exchange at a time, request drops after acknowledge
  a_r2_req_drop: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_ack) |=> !xfer_req);

  // R5: an overrun pulse only follows a full receive FIFO
  a_r5_overrun_when_full: assert property (@(posedge clk) disable iff (rst)
    evt_rx_overrun |-> ($past(rx_cnt) == FULLV));

  // R12: counts never pass the depth
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt <= FULLV) && (tx_cnt <= FULLV));

  // R7: a settled hold keeps the engine idle
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(inhibit) && inhibit && !xfer_req) |=> !xfer_req);
endmodule

bind spi_regfront spi_regfront_checker #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .soft_hit(soft_hit),
  .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_tx(xfer_tx),
  .inhibit(inhibit), .evt_rx_overrun(evt_rx_overrun),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/spi_regfront_bench.sv
module spi_regfront_bench;
  localparam int NSS   = 3;
  localparam int DEPTH = 256;

  localparam logic [4:0] W_GIE = 5'h07, W_ISR = 5'h08, W_IER = 5'h0A,
    W_SRST = 5'h10, W_CTRL = 5'h18, W_STAT = 5'h19, W_TXD = 5'h1A,
    W_RXD = 5'h1B, W_SS = 5'h1C, W_TXOCC = 5'h1D, W_RXOCC = 5'h1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        xfer_req, xfer_ack;
  logic [7:0]  xfer_tx, xfer_rx;
  logic [NSS-1:0] ss_n;
  logic        evt_rx_overrun, evt_rx_filled, evt_rx_stored;

  int n_cmp = 0, n_bad = 0;
  int eng_delay = 1, wc = 0, n_sent = 0;
  int n_ovr = 0, n_fill = 0;
  logic [7:0] sent [1024];
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_regfront #(.NUM_SS(NSS), .FIFO_DEPTH(DEPTH), .DW(8)) u_spi_regfront (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .ss_n(ss_n),
    .evt_rx_overrun(evt_rx_overrun), .evt_rx_filled(evt_rx_filled),
    .evt_rx_stored(evt_rx_stored)
  );

  // engine model: returns the inverted byte after eng_delay cycles
  initial begin
    xfer_ack = 1'b0;
    xfer_rx  = '0;
    forever begin
      @(negedge clk);
      if (xfer_ack) begin
        xfer_ack = 1'b0;
      end else if (xfer_req) begin
        wc++;
        if (wc >= eng_delay) begin
          xfer_ack = 1'b1;
          xfer_rx  = ~xfer_tx;
          if (n_sent < 1024) sent[n_sent] = xfer_tx;
          n_sent++;
          wc = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (evt_rx_overrun) n_ovr++;
      if (evt_rx_filled)  n_fill++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
    if (!bus_rvalid) chk("R3 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base_sent, base_fill, base_ovr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 xfer_req", 32'(xfer_req), 32'd0);
    chk("R1 ss_n", 32'(ss_n), 32'h7);
    brd(W_STAT, d);  chk("R1 R10 status", d, 32'h5);
    brd(W_SS, d);    chk("R1 select", d, 32'h7);
    brd(W_CTRL, d);  chk("R1 control", d, 32'h0);
    brd(W_TXOCC, d); chk("R1 txocc", d, 32'h0);
    brd(W_RXOCC, d); chk("R1 rxocc", d, 32'h0);

    // R4 empty receive read
    brd(W_RXD, d);   chk("R4 poison", d, 32'hDEADBEEF);
    brd(W_RXOCC, d); chk("R4 rxocc unchanged", d, 32'h0);
    brd(W_STAT, d);  chk("R4 status unchanged", d, 32'h5);

    // R13 select sweep
    for (int s = 0; s < 8; s++) begin
      bwr(W_SS, 32'hFFFF_FFF8 | 32'(s));
      chk("R13 ss_n", 32'(ss_n), 32'(s));
    end
    bwr(W_SS, 32'h7);

    // R2 R3 all byte values, groups of 8, varying engine delay
    for (int g = 0; g < 32; g++) begin
      eng_delay = (g % 4) + 1;
      for (int k = 0; k < 8; k++) bwr(W_TXD, {24'hC0FFEE, 8'(g * 8 + k)});
      idle(100);
      for (int k = 0; k < 8; k++) begin
        brd(W_RXD, d);
        chk("R3 returned byte", d, {24'd0, ~8'(g * 8 + k)});
      end
    end
    chk("R2 sent count", 32'(n_sent), 32'd256);
    for (int v = 0; v < 256; v++) chk("R2 send order", 32'(sent[v]), 32'(v));

    // R7 hold back exchanges
    eng_delay = 1;
    base_sent = n_sent;
    bwr(W_CTRL, 32'h100);
    brd(W_CTRL, d); chk("R7 control readback", d, 32'h100);
    bwr(W_TXD, 32'h11); bwr(W_TXD, 32'h22); bwr(W_TXD, 32'h33);
    idle(50);
    chk("R7 no exchange while held", 32'(n_sent - base_sent), 32'd0);
    brd(W_TXOCC, d); chk("R7 R11 txocc held", d, 32'd3);
    bwr(W_CTRL, 32'h0);
    idle(50);
    chk("R7 resumed", 32'(n_sent - base_sent), 32'd3);
    brd(W_RXOCC, d); chk("R11 rxocc", d, 32'd3);

    // R8 flush bits
    bwr(W_CTRL, 32'h100);
    bwr(W_TXD, 32'h44); bwr(W_TXD, 32'h55);
    bwr(W_CTRL, 32'h160);
    brd(W_CTRL, d);  chk("R8 flush bits read zero", d, 32'h100);
    brd(W_TXOCC, d); chk("R8 tx flushed", d, 32'd0);
    brd(W_RXOCC, d); chk("R8 rx flushed", d, 32'd0);
    brd(W_STAT, d);  chk("R8 R10 status empty", d, 32'h5);

    // R12 transmit full
    for (int i = 0; i < 256; i++) bwr(W_TXD, 32'(i));
    brd(W_TXOCC, d); chk("R12 txocc full", d, 32'd256);
    brd(W_STAT, d);  chk("R10 status tx full", d, 32'h9);
    bwr(W_TXD, 32'h77);
    brd(W_TXOCC, d); chk("R12 write dropped", d, 32'd256);
    bwr(W_TXOCC, 32'd5);
    brd(W_TXOCC, d); chk("R11 occupancy write ignored", d, 32'd256);
    bwr(W_STAT, 32'hF);
    brd(W_STAT, d);  chk("R10 status write ignored", d, 32'h9);

    // R14 sticky events, clear by toggle
    brd(W_ISR, d);   chk("R14 stored event sticky", d, 32'h4);
    bwr(W_ISR, 32'h4);
    brd(W_ISR, d);   chk("R14 toggle clears", d, 32'h0);

    // R6 fill, R5 overrun
    base_sent = n_sent; base_fill = n_fill; base_ovr = n_ovr;
    bwr(W_CTRL, 32'h0);
    idle(2000);
    chk("R6 all drained", 32'(n_sent - base_sent), 32'd256);
    brd(W_RXOCC, d); chk("R6 rxocc full", d, 32'd256);
    brd(W_STAT, d);  chk("R6 R10 status rx full", d, 32'h6);
    chk("R6 fill pulse", 32'(n_fill - base_fill), 32'd1);
    chk("R5 no overrun yet", 32'(n_ovr - base_ovr), 32'd0);
    brd(W_ISR, d);   chk("R6 fill event bit", d, 32'h6);
    bwr(W_TXD, 32'hE7);
    idle(20);
    chk("R5 extra byte sent", 32'(n_sent - base_sent), 32'd257);
    chk("R5 overrun pulse", 32'(n_ovr - base_ovr), 32'd1);
    brd(W_RXOCC, d); chk("R5 rxocc still full", d, 32'd256);
    brd(W_ISR, d);   chk("R5 overrun event bit", d, 32'h7);
    brd(W_RXD, d);   chk("R5 oldest byte intact", d, 32'hFF);
    brd(W_STAT, d);  chk("R10 status after pop", d, 32'h4);

    // R14 toggle single bit, plain words
    bwr(W_ISR, 32'h2);
    brd(W_ISR, d);   chk("R14 toggle one bit", d, 32'h5);
    bwr(W_IER, 32'h3);
    brd(W_IER, d);   chk("R14 enable readback", d, 32'h3);
    bwr(W_GIE, 32'h8000_0000);
    brd(W_GIE, d);   chk("R14 global readback", d, 32'h8000_0000);

    // R9 keyed soft reset
    bwr(W_SS, 32'h2);
    bwr(W_CTRL, 32'h100);
    bwr(W_TXD, 32'h99);
    bwr(W_SRST, 32'h5);
    brd(W_SS, d);    chk("R9 wrong key ignored", d, 32'h2);
    chk("R9 ss_n kept", 32'(ss_n), 32'h2);
    brd(W_TXOCC, d); chk("R9 tx kept", d, 32'd1);
    base_sent = n_sent;
    bwr(W_SRST, 32'hA);
    chk("R9 ss_n reset", 32'(ss_n), 32'h7);
    brd(W_CTRL, d);  chk("R9 control reset", d, 32'h0);
    brd(W_TXOCC, d); chk("R9 txocc reset", d, 32'd0);
    brd(W_RXOCC, d); chk("R9 rxocc reset", d, 32'd0);
    brd(W_STAT, d);  chk("R9 status reset", d, 32'h5);
    brd(W_ISR, d);   chk("R9 events reset", d, 32'h0);
    brd(W_IER, d);   chk("R9 enable reset", d, 32'h0);
    idle(20);
    chk("R9 nothing sent", 32'(n_sent - base_sent), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule